// File: doc/BRIEF.md
# Protected-Mode Range Access Guard

This block guards one physical memory region that belongs to a privileged execution mode of the core. Two configuration registers describe the region. The base register holds the region's page address and the memory type that privileged code uses there. The mask register holds an enable flag and a page mask that sets the size of the region. An address is inside the region when its masked page bits equal the masked base page bits. The region can only be reprogrammed while the core reports that it is in the privileged mode.

Each lookup presents a physical address together with the current mode. The block answers one cycle later with a registered verdict:
- Outside the privileged mode, an address inside the region is blocked.
- Inside the privileged mode, an address inside the region is allowed and carries the stored memory type.
- An address outside the region is always allowed.

A constant capability word tells software that the guard is present.

Top module: `range_guard`

## Requirements
- R1: `cap_word` has bit 11 set and every other bit clear, at all times.
- R2: Register layout. `wr_sel`=0 selects the base register: memory type in bits 7:0, page address in bits 35:12. `wr_sel`=1 selects the mask register: enable flag at bit 11, page mask in bits 35:12. An address hits when `(addr[35:12] ^ base[35:12]) & mask[35:12]` is zero and the enable flag is set.
- R3: A write made while `priv_mode` is 0 raises `wr_fault` for one cycle, on the edge that samples the write. It leaves both registers unchanged.
- R4: A write that sets any reserved bit raises `wr_fault` and changes nothing, even while `priv_mode` is 1. The reserved bits are 63:36 and 11:8 of the base register, and 63:36 and 10:0 of the mask register.
- R5: While the enable flag is clear, every lookup returns allow=1, block=0, type=0.
- R6: A hit with `priv_mode`=0 returns allow=0, block=1, type=0.
- R7: A hit with `priv_mode`=1 returns allow=1, block=0, and type equal to the stored bits 7:0 of the base register.
- R8: A miss returns allow=1, block=0, type=0 in either mode.
- R9: `rsp_valid` and the verdict appear on the edge that samples `chk_valid`=1. `rsp_valid` is 0 after an edge that samples `chk_valid`=0.
- R10: Synchronous reset clears both registers, which disables the region. Reset also clears all response outputs and `wr_fault`.
- R11: A clean write made with `priv_mode`=1 raises no fault. Lookups presented in the next cycle already use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = base register, 1 = mask register |
| wr_data | input | 64 | Write data |
| priv_mode | input | 1 | Core is in the privileged mode |
| wr_fault | output | 1 | Write refused (wrong mode or reserved bits) |
| chk_valid | input | 1 | Lookup request |
| chk_addr | input | 36 | Physical address to look up |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_allow | output | 1 | Access permitted |
| rsp_block | output | 1 | Access refused (hit from outside the mode) |
| rsp_type | output | 8 | Memory type for a privileged hit, else 0 |
| cap_word | output | 64 | Capability word, bit 11 = guard present |

## Verification
The in-RTL assertions check the following on every cycle:
- A refused write, whether from the wrong mode or with reserved bits set, leaves both registers untouched and raises the fault.
- A block verdict never comes with allow or a nonzero type.
- A privileged lookup is never blocked, and a disabled region never blocks.
- The response valid flag follows the request by exactly one cycle.

Only the bench's scenarios can show that the mask arithmetic picks the right addresses. They also show that the stored type reaches privileged hits, and that a refused write really leaves the old region in force. The bench brings the register contents out through lookups at the edges and inside of a programmed 1 MiB region.

// File: rtl/guard_pkg.sv
package guard_pkg;
  // register select encoding on the write port
  localparam logic SEL_BASE = 1'b0;
  localparam logic SEL_MASK = 1'b1;
  // capability and enable bit positions
  localparam int CAP_PRESENT_BIT = 11;
  localparam int EN_BIT          = 11;

  typedef struct packed {
    logic       allow;
    logic       block;
    logic [7:0] mtype;
  } verdict_t;
endpackage

// File: rtl/guard_regs.sv
module guard_regs #(
  parameter int DATA_W   = 64,
  parameter int PA_W     = 36,
  parameter int PAGE_LSB = 12,
  parameter int TYPE_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     priv_mode,
  output logic [PA_W-1:PAGE_LSB]   base_page,
  output logic [PA_W-1:PAGE_LSB]   mask_page,
  output logic [TYPE_W-1:0]        mem_type,
  output logic                     region_on,
  output logic                     wr_fault
);
  import guard_pkg::*;

  localparam logic [DATA_W-1:0] ONE        = DATA_W'(1);
  localparam logic [DATA_W-1:0] PAGE_FIELD = ((ONE << PA_W) - ONE) & ~((ONE << PAGE_LSB) - ONE);
  localparam logic [DATA_W-1:0] BASE_LEGAL = PAGE_FIELD | ((ONE << TYPE_W) - ONE);
  localparam logic [DATA_W-1:0] MASK_LEGAL = PAGE_FIELD | (ONE << EN_BIT);

  logic [DATA_W-1:0] base_q, mask_q;
  logic              rsvd_hit, refuse;

  always_comb begin
    rsvd_hit = (wr_sel == SEL_BASE) ? |(wr_data & ~BASE_LEGAL)
                                    : |(wr_data & ~MASK_LEGAL);
    refuse   = wr_en && (!priv_mode || rsvd_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      mask_q   <= '0;
      wr_fault <= 1'b0;
    end else begin
      wr_fault <= refuse;
      if (wr_en && !refuse) begin
        if (wr_sel == SEL_BASE) base_q <= wr_data;
        else                    mask_q <= wr_data;
      end
    end
  end

  assign base_page = base_q[PA_W-1:PAGE_LSB];
  assign mask_page = mask_q[PA_W-1:PAGE_LSB];
  assign mem_type  = base_q[TYPE_W-1:0];
  assign region_on = mask_q[EN_BIT];

  logic unused_bits;
  assign unused_bits = ^{base_q & ~BASE_LEGAL, mask_q & ~MASK_LEGAL,
                         base_q[PAGE_LSB-1:TYPE_W], mask_q[EN_BIT-1:0]};

  // R3: write outside the privileged mode is refused and changes nothing
  a_r3_mode_write_refused: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !priv_mode) |=> (wr_fault && $stable(base_q) && $stable(mask_q)));

  // R4: reserved bits refuse the write even in the privileged mode
  a_r4_reserved_refused: assert property (@(posedge clk) disable iff (rst)
    (wr_en && priv_mode && rsvd_hit) |=> (wr_fault && $stable(base_q) && $stable(mask_q)));

  // R11: a clean privileged write raises no fault
  a_r11_clean_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && priv_mode && !rsvd_hit) |=> !wr_fault);
endmodule

// File: rtl/guard_match.sv
module guard_match #(
  parameter int PA_W     = 36,
  parameter int PAGE_LSB = 12
) (
  input  logic [PA_W-1:0]          addr,
  input  logic [PA_W-1:PAGE_LSB]   base_page,
  input  logic [PA_W-1:PAGE_LSB]   mask_page,
  input  logic                     region_on,
  output logic                     hit
);
  logic [PA_W-1:PAGE_LSB] diff;

  always_comb begin
    diff = (addr[PA_W-1:PAGE_LSB] ^ base_page) & mask_page;
    hit  = region_on && (diff == '0);
  end

  logic unused_offset;
  assign unused_offset = ^addr[PAGE_LSB-1:0];
endmodule

// File: rtl/guard_resp.sv
module guard_resp #(
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic              hit,
  input  logic              priv_mode,
  input  logic [TYPE_W-1:0] mem_type,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_block,
  output logic [TYPE_W-1:0] rsp_type
);
  logic              allow_d, block_d;
  logic [TYPE_W-1:0] type_d;

  always_comb begin
    allow_d = 1'b1;
    block_d = 1'b0;
    type_d  = '0;
    if (hit) begin
      if (priv_mode) type_d = mem_type;
      else begin
        allow_d = 1'b0;
        block_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_block <= 1'b0;
      rsp_type  <= '0;
    end else begin
      rsp_valid <= chk_valid;
      if (chk_valid) begin
        rsp_allow <= allow_d;
        rsp_block <= block_d;
        rsp_type  <= type_d;
      end
    end
  end

  // R6: a block verdict carries neither allow nor a type
  a_r6_block_exclusive: assert property (@(posedge clk) disable iff (rst)
    rsp_block |-> (!rsp_allow && rsp_type == '0));

  // R9: response valid follows the request by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> rsp_valid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !rsp_valid);

  // R7: privileged lookups are never blocked
  a_r7_priv_not_blocked: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && priv_mode) |=> !rsp_block);
endmodule

// File: rtl/range_guard.sv
module range_guard #(
  parameter int DATA_W   = 64,
  parameter int PA_W     = 36,
  parameter int PAGE_LSB = 12,
  parameter int TYPE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              priv_mode,
  output logic              wr_fault,
  input  logic              chk_valid,
  input  logic [PA_W-1:0]   chk_addr,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_block,
  output logic [TYPE_W-1:0] rsp_type,
  output logic [DATA_W-1:0] cap_word
);
  import guard_pkg::*;

  logic [PA_W-1:PAGE_LSB] base_page, mask_page;
  logic [TYPE_W-1:0]      mem_type;
  logic                   region_on, hit;

  assign cap_word = DATA_W'(1) << CAP_PRESENT_BIT;

  guard_regs #(.DATA_W(DATA_W), .PA_W(PA_W), .PAGE_LSB(PAGE_LSB), .TYPE_W(TYPE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .priv_mode(priv_mode), .base_page(base_page), .mask_page(mask_page),
    .mem_type(mem_type), .region_on(region_on), .wr_fault(wr_fault)
  );

  guard_match #(.PA_W(PA_W), .PAGE_LSB(PAGE_LSB)) u_match (
    .addr(chk_addr), .base_page(base_page), .mask_page(mask_page),
    .region_on(region_on), .hit(hit)
  );

  guard_resp #(.TYPE_W(TYPE_W)) u_resp (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .hit(hit), .priv_mode(priv_mode),
    .mem_type(mem_type), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_block(rsp_block), .rsp_type(rsp_type)
  );

  // R5: a disabled region never blocks
  a_r5_disabled_allows: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !region_on) |=> (rsp_allow && !rsp_block));
endmodule

// File: tb/range_guard_tb.sv
module range_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, priv_mode = 1'b0, chk_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic [35:0] chk_addr = '0;
  logic        wr_fault, rsp_valid, rsp_allow, rsp_block;
  logic [7:0]  rsp_type;
  logic [63:0] cap_word;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  range_guard u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .priv_mode(priv_mode), .wr_fault(wr_fault), .chk_valid(chk_valid),
    .chk_addr(chk_addr), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_block(rsp_block), .rsp_type(rsp_type), .cap_word(cap_word)
  );

  typedef struct packed {
    logic        priv;
    logic [35:0] addr;
    logic        allow;
    logic        block;
    logic [7:0]  mtype;
  } vec_t;

  // region: base 0x0_8000_0000, 1 MiB, type 6
  localparam vec_t VEC [8] = '{
    '{1'b0, 36'h0_8000_0000, 1'b0, 1'b1, 8'h00},  // R6 first page, outside mode
    '{1'b1, 36'h0_8000_0000, 1'b1, 1'b0, 8'h06},  // R7 first page, in mode
    '{1'b1, 36'h0_800F_FFFF, 1'b1, 1'b0, 8'h06},  // R7 last byte
    '{1'b0, 36'h0_8010_0000, 1'b1, 1'b0, 8'h00},  // R8 just above
    '{1'b0, 36'h0_7FFF_FFFF, 1'b1, 1'b0, 8'h00},  // R8 just below
    '{1'b0, 36'h0_800A_BCDE, 1'b0, 1'b1, 8'h00},  // R6 middle
    '{1'b1, 36'h1_8000_0000, 1'b1, 1'b0, 8'h00},  // R2 high bit differs -> miss
    '{1'b1, 36'h0_8000_0FFF, 1'b1, 1'b0, 8'h06}   // R2 offset bits ignored
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [63:0] data, input logic pm);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data; priv_mode = pm;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input string req, input logic pm, input logic [35:0] a,
                        input logic ea, input logic eb, input logic [7:0] et);
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = a; priv_mode = pm;
    @(negedge clk);
    chk_valid = 1'b0;
    check(req, {53'd0, rsp_valid, ea, eb, et}, {53'd0, 1'b1, rsp_allow, rsp_block, rsp_type});
  endtask

  localparam logic [63:0] BASE_V = 64'h0_8000_0006;
  localparam logic [63:0] MASK_V = 64'hF_FFF0_0800;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10", {60'd0, rsp_valid, rsp_allow, rsp_block, wr_fault}, 64'd0);
    check("R1", cap_word, 64'h800);
    // R10/R5 region disabled after reset
    lookup("R10", 1'b0, 36'h0, 1'b1, 1'b0, 8'h00);
    // R9 valid drops when no request
    @(negedge clk);
    check("R9", {63'd0, rsp_valid}, 64'd0);
    // R3 write from outside the mode refused
    do_write(1'b1, MASK_V, 1'b0);
    check("R3", {63'd0, wr_fault}, 64'd1);
    lookup("R3", 1'b0, 36'h0_8000_0000, 1'b1, 1'b0, 8'h00);
    // R11 program in mode
    do_write(1'b0, BASE_V, 1'b1);
    check("R11", {63'd0, wr_fault}, 64'd0);
    do_write(1'b1, MASK_V, 1'b1);
    check("R11", {63'd0, wr_fault}, 64'd0);
    for (int i = 0; i < 8; i++)
      lookup("R2/R6/R7/R8 table", VEC[i].priv, VEC[i].addr, VEC[i].allow, VEC[i].block, VEC[i].mtype);
    // R3 disable attempt from outside mode refused, region stays
    do_write(1'b1, 64'h0, 1'b0);
    check("R3", {63'd0, wr_fault}, 64'd1);
    lookup("R3", 1'b0, 36'h0_8000_1000, 1'b0, 1'b1, 8'h00);
    // R4 reserved bit 9 in base refused even in mode
    do_write(1'b0, 64'h0_8000_0207, 1'b1);
    check("R4", {63'd0, wr_fault}, 64'd1);
    lookup("R4", 1'b1, 36'h0_8000_2000, 1'b1, 1'b0, 8'h06);
    // R4 reserved bit 40 in mask refused
    do_write(1'b1, 64'h100_0000_0000, 1'b1);
    check("R4", {63'd0, wr_fault}, 64'd1);
    lookup("R4", 1'b0, 36'h0_8000_3000, 1'b0, 1'b1, 8'h00);
    // R11 retype in mode; lookup the next cycle sees it
    do_write(1'b0, 64'h0_8000_0001, 1'b1);
    check("R11", {63'd0, wr_fault}, 64'd0);
    lookup("R11", 1'b1, 36'h0_8000_0000, 1'b1, 1'b0, 8'h01);
    // R5 clear enable in mode -> everything allowed
    do_write(1'b1, 64'hF_FFF0_0000, 1'b1);
    lookup("R5", 1'b0, 36'h0_8000_0000, 1'b1, 1'b0, 8'h00);
    // R10 reset clears region
    do_write(1'b1, MASK_V, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    lookup("R10", 1'b0, 36'h0_8000_0000, 1'b1, 1'b0, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule